// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block caches translations from virtual page numbers to physical page numbers. It is fully associative. Every entry stores an address-space tag, so translations that belong to different processes can sit side by side. A context switch only needs a new value on `cur_asid`, and the table is never flushed for it. A lookup carries a virtual page number, a write flag and the current address-space tag. Exactly one clock edge later the block returns hit or miss, the physical page number, the page's write permission, its dirty state, and whether the write broke the page's protection.

A page-table walker installs translations through the refill port. The replacement choice follows the per-entry recently-referenced bits. A single register holds the most recent successful translation. A lookup to that same page and tag takes its entry index from this register and skips the associative search. This path still reports a hit, and a dedicated output flags it. A one-cycle invalidate-all pulse empties the table and the bypass register.

Top module: `tlb_asid`

## Requirements
- R1: In the cycle after synchronous reset, `rsp_valid` is 0 and every entry is invalid, so the first lookup reports `rsp_hit`=0.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_valid`=1. `rsp_hit`=1 only when a valid entry matches both `lk_vpn` and `cur_asid`, and a hit returns that entry's `rsp_ppn` and `rsp_writable`.
- R3: Entries with the same page number but different address-space tags coexist, and each tag gets its own physical page.
- R4: A refill whose page and tag are not in the table goes into the lowest-numbered invalid entry.
- R5: When every entry is valid, a refill replaces the lowest-numbered entry whose recently-referenced bit is clear. A refill sets that bit on its entry, and a permitted lookup hit sets it on the entry it hits.
- R6: When every entry is valid and every recently-referenced bit is set, a refill clears all of those bits and replaces entry 0, which keeps its bit set.
- R7: A write lookup (`lk_write`=1) that hits a writable entry sets that entry's dirty bit, and the same response shows `rsp_dirty`=1. A refill leaves its entry clean.
- R8: A write lookup that hits a read-only entry returns `rsp_hit`=1 and `rsp_fault`=1. It changes no state: the dirty bit, the recently-referenced bit and the bypass register all stay as they were.
- R9: A permitted hit loads the bypass register. A later lookup to the same page and tag returns `rsp_hit`=1 and `rsp_bypass`=1, with the same data the associative search would give.
- R10: `inv_all`=1 for one cycle makes every entry and the bypass register invalid. A lookup in that same cycle reports a miss, and a refill in that same cycle is dropped.
- R11: A refill whose page and tag already hold an entry overwrites that entry in place. If the bypass register points at that entry, it stays valid and returns the new data.
- R12: A refill that evicts the entry the bypass register points at, for a different page or tag, invalidates the bypass register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_write | input | 1 | Lookup is a store (1) or a load (0) |
| cur_asid | input | ASID_W | Address-space tag of the running process |
| fill_valid | input | 1 | Refill request from the walker |
| fill_vpn | input | VPN_W | Page number being installed |
| fill_asid | input | ASID_W | Address-space tag being installed |
| fill_ppn | input | PPN_W | Physical page number being installed |
| fill_writable | input | 1 | Installed page permits writes |
| inv_all | input | 1 | Invalidate every entry and the bypass register |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_ppn | output | PPN_W | Physical page number (meaningful on hit) |
| rsp_fault | output | 1 | Write to a read-only page |
| rsp_writable | output | 1 | Hit page permits writes |
| rsp_dirty | output | 1 | Hit page's dirty state after this access |
| rsp_bypass | output | 1 | Hit served by the last-translation register |

## Verification
Most internal faults show up at the ports within a few operations. A stale or wrongly kept bypass register returns a page that the table no longer holds, or raises `rsp_bypass` on the very next lookup to that key. A wrong recently-referenced bit stays hidden until the table is full and the next refill removes the wrong entry. It therefore shows one refill later, as a miss on a page that should have stayed, or a hit on one that should have gone. Dirty and permission errors appear on the response to the access that causes them, and again on the next read of that page. The bench keeps a model of the table, fills the table past capacity on purpose, and mixes address-space tags so that each of these faults reaches a compared response.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Where a lookup found its translation.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CAM  = 2'd1,
    SRC_LAST = 2'd2
  } hit_src_e;
endpackage

// File: rtl/tlb_tag_cam.sv
// Tag store: valid bits, page numbers and address-space tags, with two
// compare ports (one for the lookup key, one for the refill key).
module tlb_tag_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inv_all,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [VPN_W-1:0]   q_vpn,
  input  logic [ASID_W-1:0]  q_asid,
  input  logic [VPN_W-1:0]   f_vpn,
  input  logic [ASID_W-1:0]  f_asid,
  output logic [ENTRIES-1:0] valid_vec,
  output logic               q_hit,
  output logic [IDX_W-1:0]   q_idx,
  output logic               f_hit,
  output logic [IDX_W-1:0]   f_idx
);
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [ENTRIES-1:0] q_match;
  logic [ENTRIES-1:0] f_match;

  always_ff @(posedge clk) begin
    if (rst || inv_all) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !inv_all) begin
      vpn_q[wr_idx]  <= wr_vpn;
      asid_q[wr_idx] <= wr_asid;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign q_match[g] = valid_q[g] && (vpn_q[g] == q_vpn) && (asid_q[g] == q_asid);
    assign f_match[g] = valid_q[g] && (vpn_q[g] == f_vpn) && (asid_q[g] == f_asid);
  end

  always_comb begin
    q_idx = '0;
    f_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (q_match[i]) q_idx = IDX_W'(i);
      if (f_match[i]) f_idx = IDX_W'(i);
    end
  end

  assign q_hit     = |q_match;
  assign f_hit     = |f_match;
  assign valid_vec = valid_q;

  // R11: refill never creates a second copy of a key
  a_r11_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q_match));
endmodule

// File: rtl/tlb_victim_sel.sv
// Chooses the entry that a refill writes.
module tlb_victim_sel #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] used_vec,
  input  logic               key_hit,
  input  logic [IDX_W-1:0]   key_idx,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               clear_used
);
  logic             have_free;
  logic [IDX_W-1:0] free_idx;
  logic             have_cold;
  logic [IDX_W-1:0] cold_idx;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    have_cold = 1'b0;
    cold_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
      if (!used_vec[i]) begin
        have_cold = 1'b1;
        cold_idx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    clear_used = 1'b0;
    if (key_hit)        victim_idx = key_idx;
    else if (have_free) victim_idx = free_idx;
    else if (have_cold) victim_idx = cold_idx;
    else begin
      victim_idx = '0;
      clear_used = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_ppn_ram.sv
// Physical page storage: one write port, registered read port.
module tlb_ppn_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 18,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_write,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_writable,
  input  logic              inv_all,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic              rsp_fault,
  output logic              rsp_writable,
  output logic              rsp_dirty,
  output logic              rsp_bypass
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] used_q, dirty_q, wable_q;
  logic [ENTRIES-1:0] cam_valid;
  logic               cam_hit, f_hit, clear_used;
  logic [IDX_W-1:0]   cam_idx, f_idx, victim_idx, sel_idx;

  // last-translation register
  logic              ltr_v, ltr_v_nx;
  logic [VPN_W-1:0]  ltr_vpn, ltr_vpn_nx;
  logic [ASID_W-1:0] ltr_asid, ltr_asid_nx;
  logic [IDX_W-1:0]  ltr_idx, ltr_idx_nx;

  hit_src_e src;
  logic     ltr_hit, hit_any, wr_ok, fault, do_lk, do_fill, touch;

  tlb_tag_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_cam (
    .clk(clk), .rst(rst), .inv_all(inv_all),
    .wr_en(do_fill), .wr_idx(victim_idx), .wr_vpn(fill_vpn), .wr_asid(fill_asid),
    .q_vpn(lk_vpn), .q_asid(cur_asid), .f_vpn(fill_vpn), .f_asid(fill_asid),
    .valid_vec(cam_valid), .q_hit(cam_hit), .q_idx(cam_idx),
    .f_hit(f_hit), .f_idx(f_idx)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_vsel (
    .valid_vec(cam_valid), .used_vec(used_q),
    .key_hit(f_hit), .key_idx(f_idx),
    .victim_idx(victim_idx), .clear_used(clear_used)
  );

  tlb_ppn_ram #(.DEPTH(ENTRIES), .WIDTH(PPN_W), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .we(do_fill), .waddr(victim_idx), .wdata(fill_ppn),
    .raddr(sel_idx), .rdata(rsp_ppn)
  );

  // lookup decode
  assign ltr_hit = ltr_v && (ltr_vpn == lk_vpn) && (ltr_asid == cur_asid);

  always_comb begin
    if (ltr_hit)      src = SRC_LAST;
    else if (cam_hit) src = SRC_CAM;
    else              src = SRC_NONE;
  end

  assign sel_idx = (src == SRC_LAST) ? ltr_idx : cam_idx;
  assign hit_any = (src != SRC_NONE);
  assign wr_ok   = wable_q[sel_idx];
  assign fault   = lk_write && !wr_ok;
  assign do_lk   = lk_valid && !inv_all;
  assign do_fill = fill_valid && !inv_all;
  assign touch   = do_lk && hit_any && !fault;

  // next value of the last-translation register
  always_comb begin
    ltr_v_nx    = ltr_v;
    ltr_vpn_nx  = ltr_vpn;
    ltr_asid_nx = ltr_asid;
    ltr_idx_nx  = ltr_idx;
    if (touch) begin
      ltr_v_nx    = 1'b1;
      ltr_vpn_nx  = lk_vpn;
      ltr_asid_nx = cur_asid;
      ltr_idx_nx  = sel_idx;
    end
    if (do_fill && ltr_v_nx && (ltr_idx_nx == victim_idx) &&
        !((ltr_vpn_nx == fill_vpn) && (ltr_asid_nx == fill_asid))) begin
      ltr_v_nx = 1'b0;
    end
    if (inv_all) ltr_v_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ltr_v    <= 1'b0;
      ltr_vpn  <= '0;
      ltr_asid <= '0;
      ltr_idx  <= '0;
    end else begin
      ltr_v    <= ltr_v_nx;
      ltr_vpn  <= ltr_vpn_nx;
      ltr_asid <= ltr_asid_nx;
      ltr_idx  <= ltr_idx_nx;
    end
  end

  // per-entry status bits
  always_ff @(posedge clk) begin
    if (rst) begin
      used_q  <= '0;
      dirty_q <= '0;
      wable_q <= '0;
    end else if (inv_all) begin
      used_q <= '0;
    end else begin
      if (touch) begin
        used_q[sel_idx] <= 1'b1;
        if (lk_write) dirty_q[sel_idx] <= 1'b1;
      end
      if (do_fill) begin
        if (clear_used) used_q <= '0;
        used_q[victim_idx]  <= 1'b1;
        dirty_q[victim_idx] <= 1'b0;
        wable_q[victim_idx] <= fill_writable;
      end
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_writable <= 1'b0;
      rsp_dirty    <= 1'b0;
      rsp_bypass   <= 1'b0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= do_lk && hit_any;
      rsp_fault    <= do_lk && hit_any && fault;
      rsp_writable <= do_lk && hit_any && wr_ok;
      rsp_dirty    <= do_lk && hit_any && (dirty_q[sel_idx] || (lk_write && wr_ok));
      rsp_bypass   <= do_lk && (src == SRC_LAST);
    end
  end

  // R2: one response per lookup, one cycle later
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  // R7: permitted write hit leaves the entry dirty
  a_r7_dirty_set: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !inv_all && !fill_valid && hit_any && lk_write && wr_ok)
    |=> dirty_q[$past(sel_idx)]);
  // R8: faulting write touches no state
  a_r8_fault_no_change: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !inv_all && !fill_valid && hit_any && fault)
    |=> ($stable(dirty_q) && $stable(used_q) && $stable(ltr_v) && $stable(ltr_idx)));
  a_r8_fault_is_hit: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_hit);
  // R9: bypass responses are hits
  a_r9_bypass_is_hit: assert property (@(posedge clk) disable iff (rst)
    rsp_bypass |-> rsp_hit);
  // R6: full wrap leaves only the refilled entry marked
  a_r6_wrap_clears: assert property (@(posedge clk) disable iff (rst)
    (do_fill && !f_hit && (&cam_valid) && (&used_q)) |=> (used_q == ENTRIES'(1)));
  // R10: invalidate-all empties the table in one cycle
  a_r10_inv_clears: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> ((cam_valid == '0) && !ltr_v));
  // R12: bypass register only ever names a live entry
  a_r12_ltr_live: assert property (@(posedge clk) disable iff (rst)
    ltr_v |-> cam_valid[ltr_idx]);
endmodule

// File: tb/tlb_asid_tb_top.sv
`timescale 1ns/1ps
module tlb_asid_tb_top;
  localparam int N      = 4;
  localparam int VPN_W  = 20;
  localparam int PPN_W  = 18;
  localparam int ASID_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lk_valid = 1'b0;
  logic [VPN_W-1:0]  lk_vpn = '0;
  logic              lk_write = 1'b0;
  logic [ASID_W-1:0] cur_asid = '0;
  logic              fill_valid = 1'b0;
  logic [VPN_W-1:0]  fill_vpn = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic [PPN_W-1:0]  fill_ppn = '0;
  logic              fill_writable = 1'b0;
  logic              inv_all = 1'b0;
  logic              rsp_valid, rsp_hit, rsp_fault, rsp_writable, rsp_dirty, rsp_bypass;
  logic [PPN_W-1:0]  rsp_ppn;

  always #4 clk = ~clk;

  tlb_asid #(.ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write),
    .cur_asid(cur_asid), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_ppn(fill_ppn), .fill_writable(fill_writable),
    .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .rsp_fault(rsp_fault), .rsp_writable(rsp_writable), .rsp_dirty(rsp_dirty),
    .rsp_bypass(rsp_bypass)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check_eq(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  typedef struct {
    bit    hit;
    bit    fault;
    bit    bypass;
    bit    dirty;
    bit    wable;
    int    ppn;
    string tag;
  } exp_t;
  exp_t sb[$];

  // reference model of the table
  bit m_v[N], m_u[N], m_d[N], m_w[N];
  int m_vpn[N], m_asid[N], m_ppn[N];
  bit l_v;
  int l_vpn, l_asid, l_idx;

  function automatic int m_find(int vpn, int asid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
    return -1;
  endfunction

  task automatic do_lookup(int vpn, int asid, bit wr, string tag);
    exp_t e;
    int   idx;
    idx      = m_find(vpn, asid);
    e.hit    = (idx >= 0);
    e.bypass = l_v && l_vpn == vpn && l_asid == asid;
    e.fault  = e.hit && wr && !m_w[idx];
    e.wable  = e.hit && m_w[idx];
    e.dirty  = e.hit && (m_d[idx] || (wr && m_w[idx]));
    e.ppn    = e.hit ? m_ppn[idx] : 0;
    e.tag    = tag;
    sb.push_back(e);
    if (e.hit && !e.fault) begin
      m_u[idx] = 1'b1;
      if (wr) m_d[idx] = 1'b1;
      l_v = 1'b1; l_vpn = vpn; l_asid = asid; l_idx = idx;
    end
    lk_valid = 1'b1;
    lk_vpn   = VPN_W'(vpn);
    cur_asid = ASID_W'(asid);
    lk_write = wr;
    @(negedge clk);
    lk_valid = 1'b0;
    lk_write = 1'b0;
  endtask

  task automatic do_fill(int vpn, int asid, int ppn, bit w);
    int idx;
    idx = m_find(vpn, asid);
    if (idx < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
    if (idx < 0) for (int i = N - 1; i >= 0; i--) if (!m_u[i]) idx = i;
    if (idx < 0) begin
      for (int i = 0; i < N; i++) m_u[i] = 1'b0;
      idx = 0;
    end
    m_v[idx] = 1'b1; m_u[idx] = 1'b1; m_d[idx] = 1'b0; m_w[idx] = w;
    m_vpn[idx] = vpn; m_asid[idx] = asid; m_ppn[idx] = ppn;
    if (l_v && l_idx == idx && !(l_vpn == vpn && l_asid == asid)) l_v = 1'b0;
    fill_valid    = 1'b1;
    fill_vpn      = VPN_W'(vpn);
    fill_asid     = ASID_W'(asid);
    fill_ppn      = PPN_W'(ppn);
    fill_writable = w;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_inv();
    for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_u[i] = 1'b0; end
    l_v = 1'b0;
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  // monitor: compare each response against the queued expectation
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        check_eq("R2", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check_eq(e.tag, "hit", int'(rsp_hit), int'(e.hit));
        check_eq(e.tag, "fault", int'(rsp_fault), int'(e.fault));
        check_eq(e.tag, "bypass", int'(rsp_bypass), int'(e.bypass));
        if (e.hit) begin
          check_eq(e.tag, "ppn", int'(rsp_ppn), e.ppn);
          check_eq(e.tag, "dirty", int'(rsp_dirty), int'(e.dirty));
          check_eq(e.tag, "writable", int'(rsp_writable), int'(e.wable));
        end
      end
    end
  end

  bit finished = 1'b0;

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_u[i] = 0; m_d[i] = 0; m_w[i] = 0; end
    l_v = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    do_lookup('h100, 1, 0, "R1");

    // placement into free slots, two tags on one page
    do_fill('h100, 1, 'h11, 1);
    do_fill('h100, 2, 'h22, 0);
    do_fill('h200, 1, 'h33, 1);
    do_lookup('h100, 2, 0, "R3");
    do_lookup('h100, 1, 0, "R2");
    do_lookup('h100, 1, 0, "R9");
    do_lookup('h100, 3, 0, "R2");
    do_lookup('h300, 1, 0, "R2");
    // store to read-only page, then confirm nothing moved
    do_lookup('h100, 2, 1, "R8");
    do_lookup('h100, 2, 0, "R8");
    do_lookup('h100, 1, 0, "R8");
    // permitted store
    do_lookup('h200, 1, 1, "R7");
    do_lookup('h200, 1, 0, "R7");
    do_fill('h400, 1, 'h44, 1);
    do_lookup('h400, 1, 0, "R4");
    // all referenced: wrap to entry 0
    do_fill('h500, 3, 'h55, 1);
    do_lookup('h100, 1, 0, "R6");
    do_lookup('h500, 3, 0, "R6");
    // first unreferenced entry goes
    do_fill('h600, 3, 'h66, 0);
    do_lookup('h100, 2, 0, "R5");
    do_lookup('h600, 3, 0, "R5");
    do_lookup('h200, 1, 0, "R5");
    // rewrite of a present key keeps the bypass register
    do_fill('h200, 1, 'h77, 0);
    do_lookup('h200, 1, 0, "R11");
    // evict the bypass entry
    do_fill('h800, 4, 'h88, 1);
    do_fill('h900, 4, 'h99, 1);
    do_fill('hA00, 4, 'hAA, 1);
    do_fill('hB00, 4, 'hBB, 1);
    do_lookup('h200, 1, 0, "R12");
    do_lookup('hB00, 4, 0, "R12");
    // invalidate everything
    do_inv();
    do_lookup('hB00, 4, 0, "R10");
    do_lookup('h900, 4, 0, "R10");
    do_fill('hC00, 5, 'hCC, 1);
    do_lookup('hC00, 5, 0, "R10");

    // mixed traffic against the model
    for (int it = 0; it < 600; it++) begin
      int r, vpn, asid;
      r    = int'($urandom % 16);
      vpn  = 'h10 + int'($urandom % 5);
      asid = 1 + int'($urandom % 2);
      if (r < 4)       do_fill(vpn, asid, int'($urandom % 'h3FFFF), bit'($urandom % 2));
      else if (r == 15) begin
        if ($urandom % 6 == 0) do_inv();
        else do_lookup(vpn, asid, 1'b0, "R9");
      end
      else do_lookup(vpn, asid, bit'($urandom % 2), "R5");
    end

    repeat (3) @(negedge clk);
    check_eq("R2", "responses outstanding", sb.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule